// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine with Selectable Bus Policy

This block copies a run of words from one place in memory to another without help from the host processor. The host loads a source address, a destination address and a word count through a small register port. It then writes the control register with the start bit set and a bus-ownership policy. The engine asks an external arbiter for the shared memory bus. It moves each word as one bus read followed by one bus write. After each word it advances both addresses by one word and lowers the remaining count. When the count reaches zero it sets a done flag that stays set and drives the interrupt line.

There are three bus policies. In burst policy the engine keeps the bus for the whole block. In stealing policy it gives the bus back after every word. In idle-only policy it asks for the bus, and uses it, only in cycles where the processor marks the bus as unused.

The sequencer has five states. IDLE waits for a start. REQ raises the request and issues the read once the bus may be used. CAP latches the returned word. WR issues the write once the bus may be used. GAP is the one-cycle release of the stealing policy.

The transitions are:
- IDLE→REQ on a start with a nonzero count.
- REQ→CAP when the read is issued.
- CAP→WR always.
- WR→IDLE on the last word.
- WR→GAP for a word that is not the last, in stealing policy.
- WR→REQ for a word that is not the last, in the other two policies.
- GAP→REQ always.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `bus_req`, `mem_rd` and `mem_wr` are low. Registers are selected by `cfg_addr[4:2]`: 0 source, 1 destination, 2 count, 3 control, 4 status. The control register reads back as {mode[2:1], start[0] reads 0}. The status register reads back as {done[1], busy[0]}.
- R2: Writing control bit 0 = 1 while idle, with a nonzero count, starts a copy. Each word is one `mem_rd` cycle followed one cycle later by no access, and then by a `mem_wr` cycle that carries the word read. The destination words end up equal to the source words.
- R3: Each moved word adds 4 to the source register and 4 to the destination register, and takes 1 from the count register. After a copy of N words the registers read start+4N, start+4N and 0.
- R4: When the last word is written, status bit 1 (done) sets and `irq` follows it. Done stays set until the host writes 1 to status bit 1. Busy (status bit 0) is high for the whole copy.
- R5: Control mode 00 (burst): `bus_req` rises once at the start and stays high until the last write.
- R6: Control mode 01 (stealing): `bus_req` is low for at least one cycle after each word that is not the last, so a copy of N words raises `bus_req` N times.
- R7: Control mode 10 (idle-only): in any cycle with `cpu_active` high, `bus_req`, `mem_rd` and `mem_wr` are low. The copy still completes correctly.
- R8: `mem_rd` and `mem_wr` are asserted only in cycles where `bus_gnt` is high.
- R9: A start with a count of zero sets done at once, does not make the engine busy, and makes no bus access.
- R10: While busy, host writes to the source, destination, count and control registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Host register write strobe |
| cfg_addr | input | 5 | Host register byte offset |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Host read data for `cfg_addr` (combinational) |
| irq | output | 1 | Completion interrupt (the done flag) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| cpu_active | input | 1 | Processor is using the bus this cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |

## Verification
The bench pulls the grant while the engine is waiting for the bus and writes new values into the source and count registers. A design that did not lock its configuration would then copy from the wrong place or for the wrong length. It counts request rises in each policy. A stealing engine that kept the bus would show one rise instead of N, and a burst engine that dropped the bus would show more than one. In idle-only policy it drives a busy pattern on `cpu_active` and counts any access made in a busy cycle; a design that ignored that input would make such accesses. It also starts a copy with a count of zero and expects done with no access, which catches an engine that would wrap the count and run away.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        MODE_BURST = 2'b00,
        MODE_STEAL = 2'b01,
        MODE_IDLE  = 2'b10,
        MODE_RSVD  = 2'b11
    } xfer_mode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_CAP,
        S_WR,
        S_GAP
    } seq_state_t;

    localparam int unsigned REG_SRC  = 0;
    localparam int unsigned REG_DST  = 1;
    localparam int unsigned REG_CNT  = 2;
    localparam int unsigned REG_CTL  = 3;
    localparam int unsigned REG_STAT = 4;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [4:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          busy,
    input  logic          step,
    input  logic          finish,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic          last_word,
    output logic          start_go,
    output xfer_mode_t    start_mode,
    output logic          done_q
);
    localparam int unsigned STRIDE = DW / 8;

    logic [CW-1:0] cnt_q;
    xfer_mode_t    mode_q;
    logic [2:0]    idx;
    logic          wr_open;
    logic          start_req;
    logic          zero_start;
    logic          clr_done;

    assign idx        = cfg_addr[4:2];
    assign wr_open    = cfg_wr && !busy;
    assign start_req  = wr_open && (idx == 3'(REG_CTL)) && cfg_wdata[0];
    assign start_go   = start_req && (cnt_q != '0);
    assign zero_start = start_req && (cnt_q == '0);
    assign start_mode = xfer_mode_t'(cfg_wdata[2:1]);
    assign clr_done   = cfg_wr && (idx == 3'(REG_STAT)) && cfg_wdata[1];
    assign last_word  = (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            mode_q <= MODE_BURST;
            done_q <= 1'b0;
        end else begin
            if (step) begin
                src_q <= src_q + AW'(STRIDE);
                dst_q <= dst_q + AW'(STRIDE);
                cnt_q <= cnt_q - CW'(1);
            end else if (wr_open) begin
                unique case (idx)
                    3'(REG_SRC): src_q  <= cfg_wdata[AW-1:0];
                    3'(REG_DST): dst_q  <= cfg_wdata[AW-1:0];
                    3'(REG_CNT): cnt_q  <= cfg_wdata[CW-1:0];
                    3'(REG_CTL): mode_q <= xfer_mode_t'(cfg_wdata[2:1]);
                    default: ;
                endcase
            end
            if (finish || zero_start) begin
                done_q <= 1'b1;
            end else if (clr_done) begin
                done_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (idx)
            3'(REG_SRC):  cfg_rdata = DW'(src_q);
            3'(REG_DST):  cfg_rdata = DW'(dst_q);
            3'(REG_CNT):  cfg_rdata = DW'(cnt_q);
            3'(REG_CTL):  cfg_rdata = DW'({mode_q, 1'b0});
            3'(REG_STAT): cfg_rdata = DW'({done_q, busy});
            default:      cfg_rdata = '0;
        endcase
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt_q == $past(cnt_q) - CW'(1)) && (src_q == $past(src_q) + AW'(STRIDE))); // R3
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr_done) |=> done_q); // R4
    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr && !step) |=> $stable(cnt_q) && $stable(dst_q) && $stable(src_q)); // R10
    AST_ZERO_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        zero_start |=> !busy && done_q); // R9
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_go,
    input  xfer_mode_t    start_mode,
    input  logic          last_word,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic          bus_gnt,
    input  logic          cpu_active,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          step,
    output logic          finish,
    output logic          bus_req,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    seq_state_t state_q, state_d;
    xfer_mode_t mode_q;
    logic [DW-1:0] hold_q;
    logic may_use;
    logic want_bus;

    assign want_bus = (state_q == S_REQ) || (state_q == S_CAP) || (state_q == S_WR);
    assign may_use  = bus_gnt && ((mode_q != MODE_IDLE) || !cpu_active);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            mode_q  <= MODE_BURST;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start_go) begin
                mode_q <= start_mode;
            end
            if (state_q == S_CAP) begin
                hold_q <= mem_rdata;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_go) state_d = S_REQ;
            S_REQ:  if (may_use)  state_d = S_CAP;
            S_CAP:  state_d = S_WR;
            S_WR: begin
                if (may_use) begin
                    if (last_word)                 state_d = S_IDLE;
                    else if (mode_q == MODE_STEAL) state_d = S_GAP;
                    else                           state_d = S_REQ;
                end
            end
            S_GAP:  state_d = S_REQ;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != S_IDLE);
        bus_req   = want_bus && ((mode_q != MODE_IDLE) || !cpu_active);
        mem_rd    = (state_q == S_REQ) && may_use;
        mem_wr    = (state_q == S_WR) && may_use;
        step      = mem_wr;
        finish    = mem_wr && last_word;
        mem_addr  = mem_rd ? src_addr : (mem_wr ? dst_addr : '0);
        mem_wdata = mem_wr ? hold_q : '0;
    end

    AST_RD_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd && !mem_wr); // R2
    AST_ACCESS_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> bus_gnt); // R8
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BURST && bus_req && !finish) |=> bus_req); // R5
    AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STEAL && mem_wr && !finish) |=> !bus_req); // R6
    AST_IDLE_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == MODE_IDLE && cpu_active) |-> !bus_req && !mem_rd && !mem_wr); // R7
endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
    import dma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [4:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    output logic          irq,
    output logic          bus_req,
    input  logic          bus_gnt,
    input  logic          cpu_active,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    logic          busy;
    logic          step;
    logic          finish;
    logic          last_word;
    logic          start_go;
    logic          done_q;
    xfer_mode_t    start_mode;
    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;

    dma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .busy       (busy),
        .step       (step),
        .finish     (finish),
        .src_q      (src_q),
        .dst_q      (dst_q),
        .last_word  (last_word),
        .start_go   (start_go),
        .start_mode (start_mode),
        .done_q     (done_q)
    );

    dma_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_go   (start_go),
        .start_mode (start_mode),
        .last_word  (last_word),
        .src_addr   (src_q),
        .dst_addr   (dst_q),
        .bus_gnt    (bus_gnt),
        .cpu_active (cpu_active),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .step       (step),
        .finish     (finish),
        .bus_req    (bus_req),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    assign irq = done_q;
endmodule

// File: tb/dma_copy_engine_tb.sv
module dma_copy_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq;
    logic        bus_req;
    logic        bus_gnt;
    logic        cpu_active = 1'b0;
    logic        cpu_hold = 1'b0;
    logic        idle_pat_en = 1'b0;
    logic        mem_rd;
    logic        mem_wr;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem [64];

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int req_rises = 0;
    int accesses = 0;
    int ungranted = 0;
    int busy_hits = 0;
    logic req_prev = 1'b0;
    logic all_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_gnt = bus_req && !cpu_hold;

    dma_copy_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .cpu_active(cpu_active),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model with one-cycle read latency, plus bus monitors
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];
        if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
        if (mem_rd || mem_wr) accesses <= accesses + 1;
        if ((mem_rd || mem_wr) && !bus_gnt) ungranted <= ungranted + 1;
        if ((mem_rd || mem_wr || bus_req) && cpu_active) busy_hits <= busy_hits + 1;
        if (bus_req && !req_prev) req_rises <= req_rises + 1;
        req_prev <= bus_req;
    end

    // busy pattern on the processor side: busy three cycles of four
    always @(negedge clk) begin
        cpu_active <= idle_pat_en && ((cyc % 4) != 0);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 400; i++) begin
            if (irq) break;
            @(negedge clk);
        end
    endtask

    task automatic setup(input int src, input int dst, input int n);
        reg_wr(5'h00, 32'(src));
        reg_wr(5'h04, 32'(dst));
        reg_wr(5'h08, 32'(n));
    endtask

    task automatic check_copy(input string req, input int src, input int dst, input int n);
        for (int i = 0; i < n; i++)
            check(req, mem[dst/4 + i], 32'hA500_0000 + 32'(src/4 + i));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int r = 0; r < 5; r++) begin
            reg_rd(5'(r * 4), v);
            check("R1 reset reg", v, 32'h0);
        end
        check("R1 irq/req/rd/wr", {28'h0, irq, bus_req, mem_rd, mem_wr}, 32'h0);
    endtask

    task automatic t_burst();
        logic [31:0] v;
        int r0 = req_rises;
        int u0 = ungranted;
        setup(32'h00, 32'h80, 4);
        reg_wr(5'h0C, 32'h1);
        reg_rd(5'h10, v);
        check("R4 busy during copy", v & 32'h1, 32'h1);
        wait_irq();
        check("R4 irq", {31'h0, irq}, 32'h1);
        check_copy("R2 burst data", 32'h00, 32'h80, 4);
        reg_rd(5'h00, v); check("R3 src end", v, 32'h10);
        reg_rd(5'h04, v); check("R3 dst end", v, 32'h90);
        reg_rd(5'h08, v); check("R3 count end", v, 32'h0);
        check("R5 one request", 32'(req_rises - r0), 32'd1);
        check("R8 ungranted accesses", 32'(ungranted - u0), 32'd0);
        repeat (3) @(negedge clk);
        reg_rd(5'h10, v); check("R4 done sticky", v, 32'h2);
        reg_wr(5'h10, 32'h2);
        reg_rd(5'h10, v); check("R4 W1C clear", v, 32'h0);
        check("R4 irq cleared", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_steal();
        logic [31:0] v;
        int r0 = req_rises;
        setup(32'h10, 32'hA0, 3);
        reg_wr(5'h0C, 32'h3);
        reg_rd(5'h0C, v); check("R1 ctl readback", v, 32'h2);
        wait_irq();
        check_copy("R6 steal data", 32'h10, 32'hA0, 3);
        check("R6 request rises", 32'(req_rises - r0), 32'd3);
        reg_wr(5'h10, 32'h2);
    endtask

    task automatic t_idle_only();
        logic [31:0] v;
        int b0 = busy_hits;
        idle_pat_en = 1'b1;
        setup(32'h20, 32'hC0, 5);
        reg_wr(5'h0C, 32'h5);
        wait_irq();
        idle_pat_en = 1'b0;
        check("R7 irq", {31'h0, irq}, 32'h1);
        check_copy("R7 idle-only data", 32'h20, 32'hC0, 5);
        check("R7 activity in busy cycles", 32'(busy_hits - b0), 32'd0);
        reg_rd(5'h04, v); check("R3 dst end idle-only", v, 32'hD4);
        reg_wr(5'h10, 32'h2);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int a0 = accesses;
        reg_wr(5'h08, 32'h0);
        reg_wr(5'h0C, 32'h1);
        reg_rd(5'h10, v); check("R9 zero count done, not busy", v, 32'h2);
        repeat (5) @(negedge clk);
        check("R9 no access", 32'(accesses - a0), 32'd0);
        reg_wr(5'h10, 32'h2);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        cpu_hold = 1'b1;
        setup(32'h30, 32'hE0, 2);
        reg_wr(5'h0C, 32'h1);
        reg_wr(5'h00, 32'h0000_0004);
        reg_wr(5'h08, 32'h7);
        reg_wr(5'h0C, 32'h4);
        reg_rd(5'h00, v); check("R10 src locked", v, 32'h30);
        reg_rd(5'h08, v); check("R10 count locked", v, 32'h2);
        reg_rd(5'h0C, v); check("R10 mode locked", v, 32'h0);
        check("R8 no access without grant", {30'h0, mem_rd, mem_wr}, 32'h0);
        cpu_hold = 1'b0;
        wait_irq();
        check_copy("R10 copy unchanged", 32'h30, 32'hE0, 2);
        check("R10 nothing past end", mem[32'hE0/4 + 2], 32'h0);
        reg_wr(5'h10, 32'h2);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = (i < 32) ? 32'hA500_0000 + 32'(i) : 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_burst();
        t_steal();
        t_idle_only();
        t_zero();
        t_lock();
        all_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!all_done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule